// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out one atomic memory operation at a time. It takes the raw 32-bit instruction word together with the values of the address register and the source register. The operation then runs in two ordered phases.

In the first phase the unit reads memory at the address-register value. It keeps the returned data in an internal holding register. In the second phase it combines the source operand with the held value, writes the result back to the same address, and writes the old memory value to the destination register.

The memory side is a plain request/response port with one request outstanding. A request stays asserted until the response arrives. The response may come in the same cycle as the request or after any number of wait cycles.

An ordering marker can travel with each request. When the instruction asks for acquire ordering, the marker goes on the read request. When it asks for release ordering, the marker goes on the write request. An error response ends the operation without a register write. An instruction outside the supported set is flagged and causes no memory traffic.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is rejected when any of these holds: bits 6:0 differ from 0x2F; bits 14:12 are neither 0x2 (32-bit) nor 0x3 (64-bit); bits 31:27 are not one of 0x00, 0x01, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C. A rejected instruction raises `illegal` for exactly one cycle, starting the cycle after acceptance. It issues no memory request and leaves `busy` low.
- R2: Both phases use the address-register value unchanged as `mem_addr`, with no offset added.
- R3: The cycle after a legal instruction is accepted, a read request (`mem_we`=0) is presented. A write request (`mem_we`=1) follows in the cycle after an error-free read response, and never before that response.
- R4: `mem_acq` equals instruction bit 26 during the read request and is low otherwise. `mem_rel` equals instruction bit 25 during the write request and is low otherwise.
- R5: The write data is computed from the source operand (S) and the old value (M), by operation code:
  - 0x00: S+M
  - 0x01: S
  - 0x04: S^M
  - 0x08: S|M
  - 0x0C: S&M
  - 0x10: signed minimum
  - 0x14: signed maximum
  - 0x18: unsigned minimum
  - 0x1C: unsigned maximum
- R6: For the 32-bit width (bits 14:12 = 0x2), only the low 32 bits of S and M are used. Minimum and maximum compare as signed or unsigned 32-bit numbers according to the code. The write data is the 32-bit result sign-extended to 64 bits. `mem_dword` is 0 for this width and 1 for the 64-bit width.
- R7: After an error-free write response, `wb_en` is high for one cycle. During that cycle `wb_rd` equals instruction bits 11:7 and `wb_data` equals the old memory value. For the 32-bit width, `wb_data` is the low 32 bits of the response, sign-extended.
- R8: An error on the read response ends the operation. No write request is issued, `wb_en` stays low, and `fault` pulses for one cycle.
- R9: An error on the write response leaves `wb_en` low and pulses `fault` for one cycle.
- R10: `busy` is high from the cycle after a legal instruction is accepted until the cycle in which the outcome (`wb_en` or `fault`) is shown. While `busy` is high, `in_valid` is ignored.
- R11: While a request waits for its response, `mem_req`, `mem_we` and `mem_addr` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_insn | input | 32 | Raw instruction word |
| in_addr | input | ADDR_W | Address register value |
| in_src | input | DATA_W | Source operand register value |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for the write phase, 0 for the read phase |
| mem_dword | output | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| mem_acq | output | 1 | Acquire-ordering marker |
| mem_rel | output | 1 | Release-ordering marker |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response for the pending request |
| mem_rsp_err | input | 1 | Response reports an error |
| mem_rsp_data | input | DATA_W | Read data |
| wb_en | output | 1 | Destination register write strobe |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | DATA_W | Value for the destination register |
| fault | output | 1 | One-cycle pulse for an aborted operation |

## Verification
The bench builds the unit with DATA_W=64 and ADDR_W=40. The narrower address width shows that the address path carries only ADDR_W bits while both operation widths still run against a full 64-bit data path.

With 64-bit data, the sign and zero boundaries of both widths can be driven: 32-bit wrap-around in addition, and 64-bit minimum against maximum. The 32-bit reads also return garbage in the upper response half, which lets the bench show that those bits are discarded.

// File: rtl/amo_rmw_pkg.sv
package amo_rmw_pkg;

  localparam logic [6:0] OPC_ATOMIC = 7'h2F;
  localparam logic [2:0] WID_WORD   = 3'h2;
  localparam logic [2:0] WID_DWORD  = 3'h3;

  typedef enum logic [4:0] {
    AOP_ADD  = 5'h00,
    AOP_SWAP = 5'h01,
    AOP_XOR  = 5'h04,
    AOP_OR   = 5'h08,
    AOP_AND  = 5'h0C,
    AOP_MIN  = 5'h10,
    AOP_MAX  = 5'h14,
    AOP_MINU = 5'h18,
    AOP_MAXU = 5'h1C
  } amo_op_e;

  typedef struct packed {
    amo_op_e    op;
    logic       word;
    logic       acq;
    logic       rel;
    logic [4:0] rd;
  } amo_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } seq_st_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_rmw_pkg::*;
(
  input  logic [31:0] insn,
  output logic        legal,
  output amo_cmd_t    cmd
);
  logic [4:0] fn5;
  logic       op_ok;
  logic       wid_ok;
  logic       unused_fields;

  assign unused_fields = ^insn[24:15];
  assign fn5 = insn[31:27];

  always_comb begin
    case (fn5)
      5'h00, 5'h01, 5'h04, 5'h08, 5'h0C,
      5'h10, 5'h14, 5'h18, 5'h1C: op_ok = 1'b1;
      default:                    op_ok = 1'b0;
    endcase
    wid_ok   = (insn[14:12] == WID_WORD) || (insn[14:12] == WID_DWORD);
    legal    = (insn[6:0] == OPC_ATOMIC) && wid_ok && op_ok;
    cmd.op   = amo_op_e'(fn5);
    cmd.word = (insn[14:12] == WID_WORD);
    cmd.acq  = insn[26];
    cmd.rel  = insn[25];
    cmd.rd   = insn[11:7];
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              word,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] old,
  output logic [DATA_W-1:0] res
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] a_v, b_v, raw;
  logic              lt_s, lt_u;

  // Sign-extending both 32-bit operands keeps signed and unsigned order,
  // so one comparator pair serves both widths.
  always_comb begin
    a_v  = word ? {{HALF{src[HALF-1]}}, src[HALF-1:0]} : src;
    b_v  = word ? {{HALF{old[HALF-1]}}, old[HALF-1:0]} : old;
    lt_s = $signed(a_v) < $signed(b_v);
    lt_u = a_v < b_v;
    case (op)
      AOP_ADD:  raw = a_v + b_v;
      AOP_SWAP: raw = a_v;
      AOP_XOR:  raw = a_v ^ b_v;
      AOP_OR:   raw = a_v | b_v;
      AOP_AND:  raw = a_v & b_v;
      AOP_MIN:  raw = lt_s ? a_v : b_v;
      AOP_MAX:  raw = lt_s ? b_v : a_v;
      AOP_MINU: raw = lt_u ? a_v : b_v;
      AOP_MAXU: raw = lt_u ? b_v : a_v;
      default:  raw = a_v;
    endcase
    res = word ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
  end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_rmw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_src,
  output logic              busy,
  output logic              illegal,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dword,
  output logic              mem_acq,
  output logic              mem_rel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              wb_en,
  output logic [4:0]        wb_rd,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault
);
  localparam int HALF = DATA_W / 2;

  seq_st_e           state_q, state_d;
  amo_cmd_t          dec_cmd, cmd_q;
  logic              dec_legal;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, old_q, old_d, new_val;
  logic              ld_cmd, ld_old;
  logic              wb_d, ill_d, flt_d;
  logic              wb_q, ill_q, flt_q;

  amo_decode u_dec (
    .insn  (in_insn),
    .legal (dec_legal),
    .cmd   (dec_cmd)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (cmd_q.op),
    .word (cmd_q.word),
    .src  (src_q),
    .old  (old_q),
    .res  (new_val)
  );

  always_comb begin
    state_d = state_q;
    ld_cmd  = 1'b0;
    ld_old  = 1'b0;
    wb_d    = 1'b0;
    ill_d   = 1'b0;
    flt_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (dec_legal) begin
            state_d = ST_LOAD;
            ld_cmd  = 1'b1;
          end else begin
            ill_d = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            state_d = ST_IDLE;
            flt_d   = 1'b1;
          end else begin
            state_d = ST_STORE;
            ld_old  = 1'b1;
          end
        end
      end
      ST_STORE: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          flt_d   = mem_rsp_err;
          wb_d    = !mem_rsp_err;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    old_d = cmd_q.word ? {{HALF{mem_rsp_data[HALF-1]}}, mem_rsp_data[HALF-1:0]}
                       : mem_rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wb_q    <= 1'b0;
      ill_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wb_q    <= wb_d;
      ill_q   <= ill_d;
      flt_q   <= flt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_cmd) begin
      cmd_q  <= dec_cmd;
      addr_q <= in_addr;
      src_q  <= in_src;
    end
    if (ld_old) begin
      old_q <= old_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_LOAD) || (state_q == ST_STORE);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_dword = mem_req && !cmd_q.word;
  assign mem_acq   = (state_q == ST_LOAD) && cmd_q.acq;
  assign mem_rel   = (state_q == ST_STORE) && cmd_q.rel;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_val;
  assign wb_en     = wb_q;
  assign wb_rd     = cmd_q.rd;
  assign wb_data   = old_q;
  assign illegal   = ill_q;
  assign fault     = flt_q;
endmodule

// File: rtl/amo_rmw_unit_chk.sv
module amo_rmw_unit_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              illegal,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_acq,
  input logic              mem_rel,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic              wb_en,
  input logic              fault
);
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !busy));

  a_r3_store_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rsp_valid && !mem_rsp_err) |=> (mem_req && mem_we));

  a_r2_same_address: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rsp_valid && !mem_rsp_err) |=> $stable(mem_addr));

  a_r4_acq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_acq |-> (mem_req && !mem_we));

  a_r4_rel_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rel |-> (mem_req && mem_we));

  a_r7_wb_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(mem_req && mem_we && mem_rsp_valid && !mem_rsp_err));

  a_r8_load_fault_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_rsp_valid && mem_rsp_err) |=> (!mem_req && fault && !wb_en));

  a_r9_store_fault_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_rsp_valid && mem_rsp_err) |=> (fault && !wb_en));

  a_r10_outcome_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || fault) |-> !busy);

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, fault, illegal}));

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
endmodule

bind amo_rmw_unit amo_rmw_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .illegal       (illegal),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_acq       (mem_acq),
  .mem_rel       (mem_rel),
  .mem_addr      (mem_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .wb_en         (wb_en),
  .fault         (fault)
);

// File: tb/amo_rmw_unit_bench.sv
`timescale 1ns/1ps
module amo_rmw_unit_bench;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [31:0]       in_insn = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_src = '0;
  logic              busy, illegal, mem_req, mem_we, mem_dword, mem_acq, mem_rel;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_err = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic              wb_en, fault;
  logic [4:0]        wb_rd;
  logic [DATA_W-1:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  amo_rmw_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_amo_rmw_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_addr(in_addr), .in_src(in_src), .busy(busy), .illegal(illegal),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword),
    .mem_acq(mem_acq), .mem_rel(mem_rel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .fault(fault)
  );

  typedef struct packed {
    logic [4:0]  f5;
    logic [2:0]  f3;
    logic        aq;
    logic        rl;
    logic [4:0]  rd;
    logic [63:0] src;
    logic [63:0] old;
    logic [63:0] nw;
    logic [63:0] rdv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'h00, 3'h3, 1'b1, 1'b0, 5'd1,  64'h5, 64'h10, 64'h15, 64'h10},
    '{5'h00, 3'h2, 1'b0, 1'b1, 5'd2,  64'h7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 64'h1},
    '{5'h01, 3'h3, 1'b1, 1'b1, 5'd3,  64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444,
                                      64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444},
    '{5'h04, 3'h2, 1'b0, 1'b0, 5'd4,  64'hF0F0_F0F0, 64'hABCD_1234_FF00_FF00,
                                      64'h0FF0_0FF0, 64'hFFFF_FFFF_FF00_FF00},
    '{5'h08, 3'h3, 1'b0, 1'b0, 5'd5,  64'h00F0, 64'h0F00, 64'h0FF0, 64'h0F00},
    '{5'h0C, 3'h3, 1'b0, 1'b1, 5'd6,  64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F,
                                      64'h0F00_0F00_0F00_0F00, 64'h0F0F_0F0F_0F0F_0F0F},
    '{5'h10, 3'h2, 1'b0, 1'b0, 5'd7,  64'hFFFF_FFFE, 64'h3, 64'hFFFF_FFFF_FFFF_FFFE, 64'h3},
    '{5'h18, 3'h2, 1'b0, 1'b0, 5'd8,  64'hFFFF_FFFE, 64'h3, 64'h3, 64'h3},
    '{5'h14, 3'h2, 1'b1, 1'b0, 5'd9,  64'hFFFF_FFFE, 64'h3, 64'h3, 64'h3},
    '{5'h1C, 3'h2, 1'b0, 1'b0, 5'd10, 64'hFFFF_FFFE, 64'h3, 64'hFFFF_FFFF_FFFF_FFFE, 64'h3},
    '{5'h10, 3'h3, 1'b0, 1'b0, 5'd11, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                                      64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
    '{5'h1C, 3'h3, 1'b0, 1'b0, 5'd12, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                                      64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
    '{5'h14, 3'h3, 1'b0, 1'b0, 5'd13, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                                      64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF},
    '{5'h00, 3'h2, 1'b0, 1'b0, 5'd14, 64'hFFFF_FFFF, 64'h1, 64'h0, 64'h1},
    '{5'h18, 3'h3, 1'b0, 1'b0, 5'd15, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  function automatic logic [31:0] mk(input logic [4:0] f5, input logic [2:0] f3,
                                     input logic aq, input logic rl,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f5, aq, rl, 5'd9, 5'd8, f3, rd, opc};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic issue(input logic [31:0] insn, input logic [ADDR_W-1:0] a,
                       input logic [63:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_addr = a; in_src = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10, R1, R7: quiet after reset
    chk("R10", "busy after reset", 64'(busy), 64'd0);
    chk("R3", "mem_req after reset", 64'(mem_req), 64'd0);
    chk("R7", "wb_en after reset", 64'(wb_en), 64'd0);
    chk("R1", "illegal after reset", 64'(illegal), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy idle", 64'(busy), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [ADDR_W-1:0] a;
      v = VECS[i];
      a = ADDR_W'(40'h12_0000_0000 + i * 8);
      issue(mk(v.f5, v.f3, v.aq, v.rl, v.rd, 7'h2F), a, v.src);
      chk("R3", "load req", 64'(mem_req), 64'd1);
      chk("R3", "load phase we", 64'(mem_we), 64'd0);
      chk("R2", "load addr", 64'(mem_addr), 64'(a));
      chk("R4", "load acq", 64'(mem_acq), 64'(v.aq));
      chk("R4", "load rel", 64'(mem_rel), 64'd0);
      chk("R6", "size", 64'(mem_dword), 64'(v.f3 == 3'h3));
      chk("R10", "busy load", 64'(busy), 64'd1);
      mem_rsp_valid = 1'b1; mem_rsp_err = 1'b0; mem_rsp_data = v.old;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R3", "store phase we", 64'(mem_we), 64'd1);
      chk("R2", "store addr", 64'(mem_addr), 64'(a));
      chk("R5", $sformatf("store data vec %0d", i), mem_wdata, v.nw);
      chk("R4", "store rel", 64'(mem_rel), 64'(v.rl));
      chk("R4", "store acq", 64'(mem_acq), 64'd0);
      mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R7", "wb_en", 64'(wb_en), 64'd1);
      chk("R7", "wb_rd", 64'(wb_rd), 64'(v.rd));
      chk("R7", $sformatf("wb_data vec %0d", i), wb_data, v.rdv);
      chk("R10", "busy after wb", 64'(busy), 64'd0);
    end

    // R1: unsupported operation code (0x02)
    issue(mk(5'h02, 3'h2, 1'b0, 1'b0, 5'd1, 7'h2F), '0, '0);
    chk("R1", "illegal fn5", 64'(illegal), 64'd1);
    chk("R1", "no req fn5", 64'(mem_req), 64'd0);
    chk("R1", "not busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R1", "illegal one cycle", 64'(illegal), 64'd0);
    // R1: bad width
    issue(mk(5'h00, 3'h0, 1'b0, 1'b0, 5'd1, 7'h2F), '0, '0);
    chk("R1", "illegal width", 64'(illegal), 64'd1);
    chk("R1", "no req width", 64'(mem_req), 64'd0);
    // R1: wrong major opcode
    issue(mk(5'h00, 3'h3, 1'b0, 1'b0, 5'd1, 7'h33), '0, '0);
    chk("R1", "illegal opcode", 64'(illegal), 64'd1);
    chk("R1", "no req opcode", 64'(mem_req), 64'd0);
    @(negedge clk);

    // R8: read error aborts
    issue(mk(5'h00, 3'h3, 1'b0, 1'b0, 5'd20, 7'h2F), 40'h100, 64'h1);
    mem_rsp_valid = 1'b1; mem_rsp_err = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    chk("R8", "fault", 64'(fault), 64'd1);
    chk("R8", "no store", 64'(mem_req), 64'd0);
    chk("R8", "no wb", 64'(wb_en), 64'd0);
    @(negedge clk);
    chk("R8", "still no store", 64'(mem_req), 64'd0);
    chk("R8", "fault one cycle", 64'(fault), 64'd0);

    // R9: write error
    issue(mk(5'h01, 3'h3, 1'b0, 1'b0, 5'd21, 7'h2F), 40'h200, 64'h2);
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h9;
    @(negedge clk);
    mem_rsp_err = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    chk("R9", "fault", 64'(fault), 64'd1);
    chk("R9", "no wb", 64'(wb_en), 64'd0);
    chk("R9", "idle", 64'(busy), 64'd0);

    // R11, R10: wait states, input ignored while busy
    issue(mk(5'h01, 3'h3, 1'b1, 1'b0, 5'd22, 7'h2F), 40'h300, 64'h77);
    in_valid = 1'b1; in_insn = mk(5'h02, 3'h2, 1'b0, 1'b0, 5'd31, 7'h2F);
    in_addr = 40'h999;
    @(negedge clk);
    chk("R11", "req held", 64'(mem_req), 64'd1);
    chk("R11", "we held", 64'(mem_we), 64'd0);
    chk("R11", "addr held", 64'(mem_addr), 64'h300);
    chk("R10", "ignored while busy", 64'(illegal), 64'd0);
    in_insn = mk(5'h00, 3'h3, 1'b0, 1'b0, 5'd31, 7'h2F);
    @(negedge clk);
    chk("R11", "addr held 2", 64'(mem_addr), 64'h300);
    in_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h55;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R5", "swap data", mem_wdata, 64'h77);
    @(negedge clk);
    chk("R11", "store held", 64'(mem_we), 64'd1);
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7", "wb_rd kept", 64'(wb_rd), 64'd22);
    chk("R7", "wb data", wb_data, 64'h55);
    @(negedge clk);
    chk("R10", "no extra op", 64'(mem_req), 64'd0);

    finish_run();
  end
endmodule